// File: doc/BRIEF.md
# SYSREF Capture and Multiframe Clock Alignment

This block keeps a local multiframe counter in step with a shared timing reference. It runs on the device clock and takes a SYSREF input that has already been registered into that clock domain. When it is enabled, it first discards a programmable number of reference edges while the clocks settle. It then waits until software arms it, and realigns the multiframe counter on the next qualifying edge. After that it supervises the continuous reference.

Each later edge is compared with the counter's wrap point. An edge that falls inside a programmable tolerance, measured in device clocks on either side of the wrap, keeps the link marked as synchronized. An edge that falls outside the tolerance raises a sticky miss flag. If the block is still armed, that edge also resets the counter to its own timing, and the tolerance is then applied around the new wrap point. In one-shot mode the arm is used up by a single alignment. In continuous mode the arm stays set, so tolerance checking alone decides when the counter realigns.

Top module: `sysref_lmfc_align`

## Requirements
- R1: The multiframe counter counts 0 to K−1, where K = `cfgPeriodM1`+1 (1 to 256). `lmfcBoundary` is high for exactly one cycle, in the cycle the count equals K−1, so boundaries are K cycles apart.
- R2: A realigning edge seen in cycle e loads the counter with 0. `lmfcResetPulse` is high in cycle e+1 only, with `alignState` = 2 (realign). In cycle e+2 `alignState` = 3 (monitor) and `inSync` = 1. The next boundary falls in cycle e+K.
- R3: `cfgFallingEdge` = 0 selects the 0→1 transition of `sysrefIn` as the alignment edge, and 1 selects the 1→0 transition. The transition that is not selected never aligns the counter.
- R4: After `enable` rises, the first `cfgSkipEdges` selected edges are discarded. The count is reloaded whenever the block is idle (`alignState` = 0).
- R5: While unarmed, no edge aligns the counter. A one-cycle `armReq` arms the block.
- R6: With `cfgOneShot` = 1, an alignment clears the arm. A later out-of-window edge then neither realigns the counter nor pulses `lmfcResetPulse`, but it drops `inSync` while the state stays at monitor. With `cfgOneShot` = 0 the arm persists.
- R7: In monitor, a selected edge seen while the count is c is in window when min(d, K−d) ≤ `cfgWindow`, where d = 0 if c = K−1 and d = c+1 otherwise. Such an edge causes no realignment and keeps `inSync` high.
- R8: In monitor, an out-of-window edge sets `windowMissSticky`. If the block is armed, the edge also realigns the counter as in R2.
- R9: A high phase of `sysrefIn` lasting fewer than 2 cycles sets `shortPulseSticky` by the second cycle after its falling transition. Two or more cycles do not set it.
- R10: A one-cycle `clrStatus` clears both sticky flags. If a new set event arrives in the same cycle, the set takes priority.
- R11: With `enable` low, `alignState` returns to 0 (idle) on the next clock and `inSync` is 0.
- R12: After reset, `alignState` = 0, `inSync` = 0, `lmfcResetPulse` = 0 and both sticky flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Starts the skip/acquire sequence; low forces idle |
| sysrefIn | input | 1 | Registered timing reference |
| cfgPeriodM1 | input | CNT_W | Multiframe length in device clocks, minus one |
| cfgFallingEdge | input | 1 | Selects the reference transition used for alignment |
| cfgSkipEdges | input | SKIP_W | Number of selected edges discarded after enable |
| armReq | input | 1 | One-cycle request to arm alignment |
| cfgOneShot | input | 1 | 1: arm consumed by one alignment; 0: arm persists |
| cfgWindow | input | CNT_W | Tolerance in cycles on each side of the wrap point |
| clrStatus | input | 1 | Clears both sticky flags |
| lmfcBoundary | output | 1 | One-cycle pulse at counter wrap |
| inSync | output | 1 | Monitoring with the last edge in tolerance |
| lmfcResetPulse | output | 1 | One-cycle pulse after each realignment |
| windowMissSticky | output | 1 | Set by an out-of-window edge |
| shortPulseSticky | output | 1 | Set by a reference high time under two cycles |
| alignState | output | 2 | 0 idle, 1 acquire, 2 realign, 3 monitor |

## Verification
The bench places reference edges exactly on the wrap point, one cycle late, one cycle early and three cycles late. A design with an off-by-one in its distance arithmetic would therefore either realign on a tolerated edge or miss a violation. It counts the boundaries after each alignment, so a latency that is one cycle long or short shows up. Edges are also sent with the block unarmed, while skipping, and after the one-shot arm has been used; a design that ignored the arm or the skip count would pulse its reset output in those cases. With falling-edge selection, the bench checks that the rising transition is ignored. It also sends one-cycle and two-cycle reference pulses to check the short-pulse threshold at its boundary.

// File: rtl/sysref_lmfc_pkg.sv
package sysref_lmfc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ACQUIRE = 2'd1,
    ST_REALIGN = 2'd2,
    ST_MONITOR = 2'd3
  } alignState_t;

  // control -> datapath
  typedef struct packed {
    logic loadLmfc;
  } ctrlStrobes_t;

  // datapath -> control
  typedef struct packed {
    logic alignEdge;
    logic inWindow;
    logic shortHigh;
  } dpEvents_t;

endpackage

// File: rtl/sysref_lmfc_datapath.sv
module sysref_lmfc_datapath
  import sysref_lmfc_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int MIN_HIGH = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sysrefIn,
  input  logic             cfgFallingEdge,
  input  logic [CNT_W-1:0] cfgPeriodM1,
  input  logic [CNT_W-1:0] cfgWindow,
  input  ctrlStrobes_t     strobes,
  output dpEvents_t        events,
  output logic             lmfcBoundary
);

  localparam int DW     = CNT_W + 1;
  localparam int HI_W   = $clog2(MIN_HIGH + 1);
  localparam logic [CNT_W-1:0] ALIGN_LOAD = '0;
  localparam logic [HI_W-1:0]  HI_SAT     = HI_W'(MIN_HIGH);

  logic             sysPrev;
  logic [HI_W-1:0]  hiCnt;
  logic [CNT_W-1:0] lmfcCnt;
  logic             atWrap;
  logic             riseEv, fallEv;
  logic [DW-1:0]    periodLen, lateDist, earlyDist, winExt;

  assign riseEv = sysrefIn & ~sysPrev;
  assign fallEv = ~sysrefIn & sysPrev;
  assign atWrap = (lmfcCnt >= cfgPeriodM1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sysPrev <= 1'b0;
      hiCnt   <= '0;
    end else begin
      sysPrev <= sysrefIn;
      if (!sysrefIn)
        hiCnt <= '0;
      else if (hiCnt < HI_SAT)
        hiCnt <= hiCnt + HI_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      lmfcCnt <= '0;
    else if (strobes.loadLmfc)
      lmfcCnt <= ALIGN_LOAD;
    else if (atWrap)
      lmfcCnt <= '0;
    else
      lmfcCnt <= lmfcCnt + CNT_W'(1);
  end

  // phase distance of the current cycle from the wrap point
  always_comb begin
    periodLen = {1'b0, cfgPeriodM1} + DW'(1);
    lateDist  = atWrap ? '0 : ({1'b0, lmfcCnt} + DW'(1));
    earlyDist = periodLen - lateDist;
    winExt    = {1'b0, cfgWindow};
  end

  always_comb begin
    events.alignEdge = cfgFallingEdge ? fallEv : riseEv;
    events.inWindow  = (lateDist <= winExt) ||
                       ((lateDist != '0) && (earlyDist <= winExt));
    events.shortHigh = fallEv && (hiCnt < HI_SAT);
  end

  assign lmfcBoundary = atWrap;

endmodule

// File: rtl/sysref_lmfc_control.sv
module sysref_lmfc_control
  import sysref_lmfc_pkg::*;
#(
  parameter int SKIP_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [SKIP_W-1:0] cfgSkipEdges,
  input  logic              armReq,
  input  logic              cfgOneShot,
  input  logic              clrStatus,
  input  dpEvents_t         events,
  output ctrlStrobes_t      strobes,
  output logic              inSync,
  output logic              lmfcResetPulse,
  output logic              windowMissSticky,
  output logic              shortPulseSticky,
  output alignState_t       state
);

  alignState_t       nextState;
  logic [SKIP_W-1:0] skipRem;
  logic              armed;
  logic              syncLost;
  logic              loadNow;
  logic              missEv;

  assign missEv = enable && (state == ST_MONITOR) &&
                  events.alignEdge && !events.inWindow;

  always_comb begin
    nextState = state;
    loadNow   = 1'b0;
    unique case (state)
      ST_IDLE:    if (enable) nextState = ST_ACQUIRE;
      ST_ACQUIRE: if (events.alignEdge && skipRem == '0 && armed) begin
                    loadNow   = 1'b1;
                    nextState = ST_REALIGN;
                  end
      ST_REALIGN: nextState = ST_MONITOR;
      ST_MONITOR: if (missEv && armed) begin
                    loadNow   = 1'b1;
                    nextState = ST_REALIGN;
                  end
      default:    nextState = ST_IDLE;
    endcase
    if (!enable) begin
      nextState = ST_IDLE;
      loadNow   = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      skipRem  <= '0;
      armed    <= 1'b0;
      syncLost <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_IDLE)
        skipRem <= cfgSkipEdges;
      else if (state == ST_ACQUIRE && events.alignEdge && skipRem != '0)
        skipRem <= skipRem - SKIP_W'(1);
      armed <= armReq | (armed & ~(loadNow & cfgOneShot));
      if (loadNow || state == ST_IDLE)
        syncLost <= 1'b0;
      else if (state == ST_MONITOR && events.alignEdge)
        syncLost <= !events.inWindow;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      windowMissSticky <= 1'b0;
      shortPulseSticky <= 1'b0;
    end else begin
      if (missEv)         windowMissSticky <= 1'b1;
      else if (clrStatus) windowMissSticky <= 1'b0;
      if (events.shortHigh) shortPulseSticky <= 1'b1;
      else if (clrStatus)   shortPulseSticky <= 1'b0;
    end
  end

  assign strobes.loadLmfc = loadNow;
  assign lmfcResetPulse   = (state == ST_REALIGN);
  assign inSync           = (state == ST_MONITOR) && !syncLost;

endmodule

// File: rtl/sysref_lmfc_align.sv
module sysref_lmfc_align
  import sysref_lmfc_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int SKIP_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              sysrefIn,
  input  logic [CNT_W-1:0]  cfgPeriodM1,
  input  logic              cfgFallingEdge,
  input  logic [SKIP_W-1:0] cfgSkipEdges,
  input  logic              armReq,
  input  logic              cfgOneShot,
  input  logic [CNT_W-1:0]  cfgWindow,
  input  logic              clrStatus,
  output logic              lmfcBoundary,
  output logic              inSync,
  output logic              lmfcResetPulse,
  output logic              windowMissSticky,
  output logic              shortPulseSticky,
  output logic [1:0]        alignState
);

  ctrlStrobes_t strobes;
  dpEvents_t    events;
  alignState_t  stateQ;

  sysref_lmfc_datapath #(.CNT_W(CNT_W), .MIN_HIGH(2)) uDatapath (
    .clk            (clk),
    .rstN           (rstN),
    .sysrefIn       (sysrefIn),
    .cfgFallingEdge (cfgFallingEdge),
    .cfgPeriodM1    (cfgPeriodM1),
    .cfgWindow      (cfgWindow),
    .strobes        (strobes),
    .events         (events),
    .lmfcBoundary   (lmfcBoundary)
  );

  sysref_lmfc_control #(.SKIP_W(SKIP_W)) uControl (
    .clk              (clk),
    .rstN             (rstN),
    .enable           (enable),
    .cfgSkipEdges     (cfgSkipEdges),
    .armReq           (armReq),
    .cfgOneShot       (cfgOneShot),
    .clrStatus        (clrStatus),
    .events           (events),
    .strobes          (strobes),
    .inSync           (inSync),
    .lmfcResetPulse   (lmfcResetPulse),
    .windowMissSticky (windowMissSticky),
    .shortPulseSticky (shortPulseSticky),
    .state            (stateQ)
  );

  assign alignState = stateQ;

endmodule

// File: rtl/sysref_lmfc_checker.sv
module sysref_lmfc_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic [CNT_W-1:0] cfgPeriodM1,
  input logic             clrStatus,
  input logic             lmfcBoundary,
  input logic             inSync,
  input logic             lmfcResetPulse,
  input logic             windowMissSticky,
  input logic             shortPulseSticky,
  input logic [1:0]       alignState
);

  assert_boundary_single_R1: assert property (@(posedge clk) disable iff (!rstN)
    (lmfcBoundary && cfgPeriodM1 != '0 && $stable(cfgPeriodM1)) |=> !lmfcBoundary);

  assert_reset_pulse_width_R2: assert property (@(posedge clk) disable iff (!rstN)
    lmfcResetPulse |=> !lmfcResetPulse);

  assert_realign_to_monitor_R2: assert property (@(posedge clk) disable iff (!rstN)
    (lmfcResetPulse && enable) |=> (alignState == 2'd3));

  assert_sync_in_monitor_R7: assert property (@(posedge clk) disable iff (!rstN)
    inSync |-> (alignState == 2'd3));

  assert_miss_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (windowMissSticky && !clrStatus) |=> windowMissSticky);

  assert_short_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (shortPulseSticky && !clrStatus) |=> shortPulseSticky);

  assert_idle_when_off_R11: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (alignState == 2'd0 && !inSync));

endmodule

bind sysref_lmfc_align sysref_lmfc_checker #(.CNT_W(CNT_W)) uChecker (
  .clk              (clk),
  .rstN             (rstN),
  .enable           (enable),
  .cfgPeriodM1      (cfgPeriodM1),
  .clrStatus        (clrStatus),
  .lmfcBoundary     (lmfcBoundary),
  .inSync           (inSync),
  .lmfcResetPulse   (lmfcResetPulse),
  .windowMissSticky (windowMissSticky),
  .shortPulseSticky (shortPulseSticky),
  .alignState       (alignState)
);

// File: tb/tb_sysref_lmfc_align.sv
`timescale 1ns/1ps
module tb_sysref_lmfc_align;

  localparam int K = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       sysrefIn = 1'b0;
  logic [7:0] cfgPeriodM1 = 8'(K - 1);
  logic       cfgFallingEdge = 1'b0;
  logic [7:0] cfgSkipEdges = 8'd0;
  logic       armReq = 1'b0;
  logic       cfgOneShot = 1'b0;
  logic [7:0] cfgWindow = 8'd1;
  logic       clrStatus = 1'b0;
  logic       lmfcBoundary, inSync, lmfcResetPulse;
  logic       windowMissSticky, shortPulseSticky;
  logic [1:0] alignState;

  int checks = 0;
  int errors = 0;
  int resetCount = 0;

  always #10 clk = ~clk;

  sysref_lmfc_align dut (
    .clk(clk), .rstN(rstN), .enable(enable), .sysrefIn(sysrefIn),
    .cfgPeriodM1(cfgPeriodM1), .cfgFallingEdge(cfgFallingEdge),
    .cfgSkipEdges(cfgSkipEdges), .armReq(armReq), .cfgOneShot(cfgOneShot),
    .cfgWindow(cfgWindow), .clrStatus(clrStatus),
    .lmfcBoundary(lmfcBoundary), .inSync(inSync),
    .lmfcResetPulse(lmfcResetPulse), .windowMissSticky(windowMissSticky),
    .shortPulseSticky(shortPulseSticky), .alignState(alignState)
  );

  always @(negedge clk) if (rstN && lmfcResetPulse) resetCount++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic sendPulse(input int hi);
    sysrefIn = 1'b1;
    fork
      begin
        repeat (hi) @(negedge clk);
        sysrefIn = 1'b0;
      end
    join_none
  endtask

  task automatic waitBoundary();
    int guard = 0;
    @(negedge clk);
    while (!lmfcBoundary && guard < 600) begin
      @(negedge clk);
      guard++;
    end
    if (guard >= 600) chk("R1 boundary timeout", 0, 1);
  endtask

  task automatic armPulse();
    armReq = 1'b1;
    @(negedge clk);
    armReq = 1'b0;
  endtask

  task automatic clearPulse();
    clrStatus = 1'b1;
    @(negedge clk);
    clrStatus = 1'b0;
  endtask

  task automatic testReset();
    chk("R12 state", alignState, 0);
    chk("R12 inSync", inSync, 0);
    chk("R12 resetPulse", lmfcResetPulse, 0);
    chk("R12 miss sticky", windowMissSticky, 0);
    chk("R12 short sticky", shortPulseSticky, 0);
  endtask

  task automatic testPeriod();
    int n = 0;
    waitBoundary();
    @(negedge clk);
    chk("R1 boundary one cycle", lmfcBoundary, 0);
    n = 1;
    while (!lmfcBoundary && n < 600) begin
      @(negedge clk);
      n++;
    end
    chk("R1 boundary spacing", n, K);
  endtask

  task automatic testUnarmed();
    int base = resetCount;
    enable = 1'b1;
    repeat (3) @(negedge clk);
    sendPulse(2);
    repeat (8) @(negedge clk);
    chk("R5 no align unarmed", resetCount - base, 0);
    chk("R5 state acquire", alignState, 1);
  endtask

  task automatic testAlign();
    int firstB = 0;
    armPulse();
    repeat (2) @(negedge clk);
    sendPulse(2);
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk);
      if (i == 1) begin
        chk("R2 reset pulse", lmfcResetPulse, 1);
        chk("R2 realign state", alignState, 2);
      end
      if (i == 2) begin
        chk("R2 monitor state", alignState, 3);
        chk("R2 inSync", inSync, 1);
        chk("R2 pulse one cycle", lmfcResetPulse, 0);
      end
      if (lmfcBoundary && firstB == 0) firstB = i;
    end
    chk("R2 boundary latency", firstB, K);
  endtask

  task automatic testInWindow();
    int base = resetCount;
    waitBoundary();
    sendPulse(2);
    repeat (3) @(negedge clk);
    waitBoundary();
    @(negedge clk);
    sendPulse(2);
    repeat (3) @(negedge clk);
    waitBoundary();
    repeat (K - 1) @(negedge clk);
    sendPulse(2);
    repeat (4) @(negedge clk);
    chk("R7 no realign in window", resetCount - base, 0);
    chk("R7 inSync held", inSync, 1);
    chk("R7 no miss flag", windowMissSticky, 0);
  endtask

  task automatic testOutWindow();
    int firstB = 0;
    waitBoundary();
    repeat (3) @(negedge clk);
    sendPulse(2);
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      if (i == 1) chk("R8 realign pulse", lmfcResetPulse, 1);
      if (lmfcBoundary && firstB == 0) firstB = i;
    end
    chk("R8 new boundary", firstB, K);
    chk("R8 miss sticky", windowMissSticky, 1);
    chk("R8 back in sync", inSync, 1);
    clearPulse();
    @(negedge clk);
    chk("R10 miss cleared", windowMissSticky, 0);
  endtask

  task automatic testOneShot();
    int base;
    enable = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11 idle", alignState, 0);
    chk("R11 inSync low", inSync, 0);
    cfgOneShot = 1'b1;
    enable = 1'b1;
    armPulse();
    repeat (2) @(negedge clk);
    sendPulse(2);
    @(negedge clk);
    chk("R6 one-shot aligns", lmfcResetPulse, 1);
    repeat (4) @(negedge clk);
    base = resetCount;
    waitBoundary();
    repeat (3) @(negedge clk);
    sendPulse(2);
    repeat (10) @(negedge clk);
    chk("R6 no realign after arm used", resetCount - base, 0);
    chk("R6 inSync dropped", inSync, 0);
    chk("R6 stays monitor", alignState, 3);
    chk("R8 miss flagged unarmed", windowMissSticky, 1);
    armPulse();
    waitBoundary();
    repeat (3) @(negedge clk);
    sendPulse(2);
    repeat (6) @(negedge clk);
    chk("R6 rearm realigns", resetCount - base, 1);
  endtask

  task automatic testSkip();
    int base;
    clearPulse();
    enable = 1'b0;
    cfgOneShot = 1'b0;
    cfgSkipEdges = 8'd2;
    repeat (2) @(negedge clk);
    enable = 1'b1;
    armPulse();
    base = resetCount;
    for (int k = 0; k < 3; k++) begin
      sendPulse(2);
      repeat (6) @(negedge clk);
      if (k < 2) chk("R4 edge skipped", resetCount - base, 0);
      else begin
        chk("R4 third edge aligns", resetCount - base, 1);
        chk("R4 monitor", alignState, 3);
      end
    end
  endtask

  task automatic testFalling();
    int firstB = 0;
    enable = 1'b0;
    cfgSkipEdges = 8'd0;
    cfgFallingEdge = 1'b1;
    repeat (2) @(negedge clk);
    enable = 1'b1;
    repeat (3) @(negedge clk);
    sendPulse(3);
    for (int i = 1; i <= 14; i++) begin
      @(negedge clk);
      if (i == 1) chk("R3 rising ignored", lmfcResetPulse, 0);
      if (i == 4) chk("R3 falling aligns", lmfcResetPulse, 1);
      if (i >= 5 && lmfcBoundary && firstB == 0) firstB = i;
    end
    chk("R3 boundary after fall", firstB, K + 3);
    cfgFallingEdge = 1'b0;
  endtask

  task automatic testShort();
    repeat (2) @(negedge clk);
    clearPulse();
    sendPulse(2);
    repeat (5) @(negedge clk);
    chk("R9 two-cycle pulse ok", shortPulseSticky, 0);
    sendPulse(1);
    repeat (3) @(negedge clk);
    chk("R9 short pulse flagged", shortPulseSticky, 1);
    repeat (3) @(negedge clk);
    clearPulse();
    @(negedge clk);
    chk("R10 short cleared", shortPulseSticky, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPeriod();
    testUnarmed();
    testAlign();
    testInWindow();
    testOutWindow();
    testOneShot();
    testSkip();
    testFalling();
    testShort();
    enable = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11 final idle", alignState, 0);
    chk("R11 final inSync", inSync, 0);
    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    finishRun();
  end

endmodule